// File: doc/BRIEF.md
# Randomized Dual-Path Share Exchanger

This block sits between two identical copies of a masked block-cipher datapath. Each copy carries its cipher state as three Boolean shares of 64 bits each. One copy is the original path and the other is the redundant path. Both paths use the same share splitting and the same mask randomness, so without a fault they hold equal states. At every round boundary the exchanger registers both incoming shared states. While it registers them, it trades chosen 4-bit nibbles of one designated share between the two paths. A fault injected in one path therefore spreads into the other along a pattern that the attacker cannot predict.

A 16-bit random word picks the traded nibble positions. It is captured by a start strobe before an encryption begins and holds for all rounds of that encryption. After the last round boundary the block folds the three shares of the original path into the ciphertext. It marks that ciphertext with a one-cycle valid pulse. The redundant path's result is never emitted. The round function, the random source and any fault-detection logic live outside this block.

Top module: `xchg_top`

## Requirements
- R1: Reset clears both stored shared states, the captured swap mask, the busy flag and the valid pulse, so every output reads zero after reset.
- R2: A start strobe while idle captures `swap_mask_i` and raises `busy_o` in the following cycle.
- R3: A start strobe while busy has no effect: the captured mask and the round count keep their values, so the running encryption keeps its swap pattern and its length.
- R4: On a round strobe while busy, nibble k (bits 4k+3..4k) of share XCHG_SHARE (default share 0, bits 63..0 of each state vector) is taken from the other path when mask bit k is 1, and from its own path when bit k is 0.
- R5: Shares other than XCHG_SHARE (bits 191..64 by default) are registered from their own path unchanged on every round strobe.
- R6: The mask captured at start applies unchanged to every round of that encryption.
- R7: A round strobe while idle leaves both stored states unchanged.
- R8: The ROUNDS-th round strobe after start (default 32) makes `cipher_vld_o` high for exactly one cycle, in the cycle after that strobe, and drops `busy_o` in that same cycle. `cipher_o` equals the XOR of the three original-path shares then on `orig_out_o`.
- R9: When both paths receive equal shared states, both swapped outputs are equal, whatever the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an encryption; captures the swap mask when idle |
| swap_mask_i | input | 16 | Random nibble-swap selection, bit k for nibble k |
| round_tick_i | input | 1 | Round boundary strobe; registers the incoming states |
| orig_in_i | input | 192 | Original path shared state, share s at bits 64s+63..64s |
| red_in_i | input | 192 | Redundant path shared state, same layout |
| orig_out_o | output | 192 | Registered, swapped original path state |
| red_out_o | output | 192 | Registered, swapped redundant path state |
| cipher_o | output | 64 | XOR of the three original-path shares |
| cipher_vld_o | output | 1 | One-cycle pulse marking the final ciphertext |
| busy_o | output | 1 | High from start until the ciphertext is valid |

## Verification
The assertions check several rules on every cycle. They check the nibble selection of the exchanged share against the captured mask, and the pass-through of the other shares. They check that the mask and the stored states stay frozen outside their update conditions, that start is ignored while busy, and that the valid pulse is single and lines up with the last round and the fall of busy. Other behaviour only the bench's scenarios can show. These are end-to-end ciphertexts over whole encryptions with changing per-round data, the all-zero and all-one masks, a start poked in the middle of a run, a round strobe while idle, and equal-path inputs giving equal outputs.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;
endpackage

// File: rtl/xchg_seq.sv
module xchg_seq
  import xchg_pkg::*;
#(
  parameter int ROUNDS = 32,
  parameter int MASK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              busy_o,
  output logic [MASK_W-1:0] mask_q_o,
  output logic              cap_o,
  output logic              last_o,
  output logic              vld_o
);
  localparam int CNT_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

  phase_e             phase_q;
  logic [CNT_W-1:0]   rnd_q;
  logic [MASK_W-1:0]  mask_q;
  logic               vld_q;

  assign busy_o   = (phase_q == PH_RUN);
  assign cap_o    = busy_o && tick_i;
  assign last_o   = (rnd_q == CNT_W'(ROUNDS - 1));
  assign mask_q_o = mask_q;
  assign vld_o    = vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      rnd_q   <= '0;
      mask_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_RUN;
            mask_q  <= mask_i;
            rnd_q   <= '0;
          end
        end
        PH_RUN: begin
          if (tick_i) begin
            if (last_o) begin
              phase_q <= PH_IDLE;
              rnd_q   <= '0;
              vld_q   <= 1'b1;
            end else begin
              rnd_q <= rnd_q + CNT_W'(1);
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xchg_net.sv
module xchg_net #(
  parameter int STATE_W    = 64,
  parameter int NIB_W      = 4,
  parameter int SHARES     = 3,
  parameter int XCHG_SHARE = 0,
  localparam int NIBS      = STATE_W / NIB_W,
  localparam int VEC_W     = SHARES * STATE_W
) (
  input  logic [VEC_W-1:0] orig_i,
  input  logic [VEC_W-1:0] red_i,
  input  logic [NIBS-1:0]  mask_i,
  output logic [VEC_W-1:0] orig_o,
  output logic [VEC_W-1:0] red_o
);
  for (genvar s = 0; s < SHARES; s++) begin : g_share
    for (genvar n = 0; n < NIBS; n++) begin : g_nib
      localparam int LO = s * STATE_W + n * NIB_W;
      if (s == XCHG_SHARE) begin : g_swap
        assign orig_o[LO +: NIB_W] = mask_i[n] ? red_i[LO +: NIB_W]  : orig_i[LO +: NIB_W];
        assign red_o[LO +: NIB_W]  = mask_i[n] ? orig_i[LO +: NIB_W] : red_i[LO +: NIB_W];
      end else begin : g_keep
        assign orig_o[LO +: NIB_W] = orig_i[LO +: NIB_W];
        assign red_o[LO +: NIB_W]  = red_i[LO +: NIB_W];
      end
    end
  end
endmodule

// File: rtl/xchg_fold.sv
module xchg_fold #(
  parameter int STATE_W = 64,
  parameter int SHARES  = 3,
  localparam int VEC_W  = SHARES * STATE_W
) (
  input  logic [VEC_W-1:0]   shares_i,
  output logic [STATE_W-1:0] value_o
);
  function automatic logic [STATE_W-1:0] fold(input logic [VEC_W-1:0] v);
    logic [STATE_W-1:0] acc;
    acc = '0;
    for (int s = 0; s < SHARES; s++) acc ^= v[s*STATE_W +: STATE_W];
    return acc;
  endfunction

  assign value_o = fold(shares_i);
endmodule

// File: rtl/xchg_top.sv
module xchg_top #(
  parameter int STATE_W    = 64,
  parameter int NIB_W      = 4,
  parameter int SHARES     = 3,
  parameter int ROUNDS     = 32,
  parameter int XCHG_SHARE = 0,
  localparam int NIBS      = STATE_W / NIB_W,
  localparam int VEC_W     = SHARES * STATE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [NIBS-1:0]    swap_mask_i,
  input  logic               round_tick_i,
  input  logic [VEC_W-1:0]   orig_in_i,
  input  logic [VEC_W-1:0]   red_in_i,
  output logic [VEC_W-1:0]   orig_out_o,
  output logic [VEC_W-1:0]   red_out_o,
  output logic [STATE_W-1:0] cipher_o,
  output logic               cipher_vld_o,
  output logic               busy_o
);
  logic [NIBS-1:0]  mask_q;
  logic             capture;
  logic             last_rnd;
  logic [VEC_W-1:0] orig_mix;
  logic [VEC_W-1:0] red_mix;
  logic [VEC_W-1:0] orig_q;
  logic [VEC_W-1:0] red_q;

  xchg_seq #(.ROUNDS(ROUNDS), .MASK_W(NIBS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .tick_i   (round_tick_i),
    .mask_i   (swap_mask_i),
    .busy_o   (busy_o),
    .mask_q_o (mask_q),
    .cap_o    (capture),
    .last_o   (last_rnd),
    .vld_o    (cipher_vld_o)
  );

  xchg_net #(
    .STATE_W(STATE_W), .NIB_W(NIB_W), .SHARES(SHARES), .XCHG_SHARE(XCHG_SHARE)
  ) u_net (
    .orig_i (orig_in_i),
    .red_i  (red_in_i),
    .mask_i (mask_q),
    .orig_o (orig_mix),
    .red_o  (red_mix)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      orig_q <= '0;
      red_q  <= '0;
    end else if (capture) begin
      orig_q <= orig_mix;
      red_q  <= red_mix;
    end
  end

  assign orig_out_o = orig_q;
  assign red_out_o  = red_q;

  xchg_fold #(.STATE_W(STATE_W), .SHARES(SHARES)) u_fold (
    .shares_i (orig_q),
    .value_o  (cipher_o)
  );
endmodule

// File: rtl/xchg_chk.sv
module xchg_chk #(
  parameter int STATE_W    = 64,
  parameter int NIB_W      = 4,
  parameter int SHARES     = 3,
  parameter int XCHG_SHARE = 0,
  localparam int NIBS      = STATE_W / NIB_W,
  localparam int VEC_W     = SHARES * STATE_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic [NIBS-1:0]    swap_mask_i,
  input logic               round_tick_i,
  input logic [VEC_W-1:0]   orig_in_i,
  input logic [VEC_W-1:0]   red_in_i,
  input logic [VEC_W-1:0]   orig_out_o,
  input logic [VEC_W-1:0]   red_out_o,
  input logic [STATE_W-1:0] cipher_o,
  input logic               cipher_vld_o,
  input logic               busy_o,
  input logic [NIBS-1:0]    mask_q,
  input logic               last_rnd
);
  localparam int XO = XCHG_SHARE * STATE_W;

  logic [STATE_W-1:0] wide_mask;
  for (genvar n = 0; n < NIBS; n++) begin : g_wm
    assign wide_mask[n*NIB_W +: NIB_W] = {NIB_W{mask_q[n]}};
  end

  logic [STATE_W-1:0] orig_sum;
  always_comb begin
    orig_sum = '0;
    for (int s = 0; s < SHARES; s++) orig_sum ^= orig_out_o[s*STATE_W +: STATE_W];
  end

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start_i |=> busy_o && (mask_q == $past(swap_mask_i)));

  assert_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !round_tick_i |=> busy_o);

  assert_swap_orig_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && round_tick_i |=> orig_out_o[XO +: STATE_W] ==
      (($past(orig_in_i[XO +: STATE_W]) & ~$past(wide_mask)) |
       ($past(red_in_i[XO +: STATE_W]) & $past(wide_mask))));

  assert_swap_red_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && round_tick_i |=> red_out_o[XO +: STATE_W] ==
      (($past(red_in_i[XO +: STATE_W]) & ~$past(wide_mask)) |
       ($past(orig_in_i[XO +: STATE_W]) & $past(wide_mask))));

  for (genvar s = 0; s < SHARES; s++) begin : g_keep
    if (s != XCHG_SHARE) begin : g_chk
      assert_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && round_tick_i |=>
          orig_out_o[s*STATE_W +: STATE_W] == $past(orig_in_i[s*STATE_W +: STATE_W]) &&
          red_out_o[s*STATE_W +: STATE_W]  == $past(red_in_i[s*STATE_W +: STATE_W]));
    end
  end

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(mask_q));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable(orig_out_o) && $stable(red_out_o));

  assert_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && round_tick_i && last_rnd |=> cipher_vld_o && !busy_o);

  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cipher_vld_o |=> !cipher_vld_o);

  assert_fold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cipher_vld_o |-> cipher_o == orig_sum);
endmodule

bind xchg_top xchg_chk #(
  .STATE_W(STATE_W), .NIB_W(NIB_W), .SHARES(SHARES), .XCHG_SHARE(XCHG_SHARE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .swap_mask_i  (swap_mask_i),
  .round_tick_i (round_tick_i),
  .orig_in_i    (orig_in_i),
  .red_in_i     (red_in_i),
  .orig_out_o   (orig_out_o),
  .red_out_o    (red_out_o),
  .cipher_o     (cipher_o),
  .cipher_vld_o (cipher_vld_o),
  .busy_o       (busy_o),
  .mask_q       (mask_q),
  .last_rnd     (last_rnd)
);

// File: tb/tb_xchg_top.sv
module tb_xchg_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROUNDS     = 32;
  localparam int VEC_W      = 192;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [15:0]      swap_mask_i = '0;
  logic             round_tick_i = 1'b0;
  logic [VEC_W-1:0] orig_in_i = '0;
  logic [VEC_W-1:0] red_in_i = '0;
  logic [VEC_W-1:0] orig_out_o, red_out_o;
  logic [63:0]      cipher_o;
  logic             cipher_vld_o, busy_o;

  int checks = 0;
  int failures = 0;
  logic [63:0] exp_q[$];
  logic [VEC_W-1:0] last_orig, last_red;

  always #(CLK_PERIOD/2) clk = ~clk;

  xchg_top dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .swap_mask_i(swap_mask_i),
    .round_tick_i(round_tick_i), .orig_in_i(orig_in_i), .red_in_i(red_in_i),
    .orig_out_o(orig_out_o), .red_out_o(red_out_o), .cipher_o(cipher_o),
    .cipher_vld_o(cipher_vld_o), .busy_o(busy_o)
  );

  task automatic check(input bit ok, input string req, input logic [VEC_W-1:0] act,
                       input logic [VEC_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [VEC_W-1:0] rnd_vec();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  // Model: share 0 trades nibble k when mask bit k is set; shares 1 and 2 stay.
  function automatic logic [VEC_W-1:0] model(input logic [VEC_W-1:0] own,
                                             input logic [VEC_W-1:0] other,
                                             input logic [15:0] m);
    logic [VEC_W-1:0] r;
    r = own;
    for (int k = 0; k < 16; k++)
      if (m[k]) r[4*k +: 4] = other[4*k +: 4];
    return r;
  endfunction

  function automatic logic [63:0] xor3(input logic [VEC_W-1:0] v);
    return v[63:0] ^ v[127:64] ^ v[191:128];
  endfunction

  // Monitor: pops the scoreboard on every valid pulse.
  initial begin
    forever begin
      @(negedge clk);
      if (cipher_vld_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected valid", {128'b0, cipher_o}, '0);
        end else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          check(cipher_o == e, "R8 ciphertext", {128'b0, cipher_o}, {128'b0, e});
          check(!busy_o, "R8 busy low with valid", {191'b0, busy_o}, '0);
        end
      end
    end
  end

  task automatic run_enc(input logic [15:0] m, input bit same_paths, input int poke_at);
    @(negedge clk);
    start_i = 1'b1; swap_mask_i = m;
    @(negedge clk);
    start_i = 1'b0; swap_mask_i = ~m;
    check(busy_o, "R2 busy after start", {191'b0, busy_o}, 1);
    for (int r = 0; r < ROUNDS; r++) begin
      logic [VEC_W-1:0] a, b, eo, er;
      a = rnd_vec();
      b = same_paths ? a : rnd_vec();
      eo = model(a, b, m);
      er = model(b, a, m);
      if (r == ROUNDS - 1) exp_q.push_back(xor3(eo));
      orig_in_i = a; red_in_i = b; round_tick_i = 1'b1;
      @(negedge clk);
      round_tick_i = 1'b0;
      check(orig_out_o == eo, "R4/R5/R6 original path", orig_out_o, eo);
      check(red_out_o == er, "R4/R5/R6 redundant path", red_out_o, er);
      if (same_paths)
        check(orig_out_o == red_out_o, "R9 equal paths", orig_out_o, red_out_o);
      if (r == ROUNDS - 1)
        check(!busy_o, "R8 busy drops", {191'b0, busy_o}, 0);
      else
        check(busy_o, "R8 busy held until last round", {191'b0, busy_o}, 1);
      last_orig = eo; last_red = er;
      if (r == poke_at) begin
        start_i = 1'b1; swap_mask_i = ~m;   // R3: ignored while busy
      end
      @(negedge clk);
      start_i = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(orig_out_o == '0 && red_out_o == '0, "R1 states cleared", orig_out_o, '0);
    check(!busy_o && !cipher_vld_o && cipher_o == '0, "R1 flags cleared",
          {126'b0, busy_o, cipher_vld_o, cipher_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    run_enc(16'hA5C3, 1'b0, 5);     // R3 poke mid-run, R6 same mask throughout
    @(negedge clk);
    // R7: idle round strobe ignored
    orig_in_i = rnd_vec(); red_in_i = rnd_vec(); round_tick_i = 1'b1;
    @(negedge clk);
    round_tick_i = 1'b0;
    check(orig_out_o == last_orig, "R7 idle original held", orig_out_o, last_orig);
    check(red_out_o == last_red, "R7 idle redundant held", red_out_o, last_red);
    check(!busy_o, "R7 idle strobe does not start", {191'b0, busy_o}, 0);

    run_enc(16'h0000, 1'b0, -1);    // R4 no nibble traded
    run_enc(16'hFFFF, 1'b0, 10);    // R4 every nibble traded
    run_enc(16'h1234, 1'b1, -1);    // R9 equal paths
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R8 all ciphertexts seen", VEC_W'(exp_q.size()), '0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule